// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencing Controller

This block is the control state machine of a static memory whose every cell has a nonvolatile shadow. It decides when the array contents are copied into the shadow cells (store) and when they are copied back (recall). It also opens and closes normal SRAM access around those transfers. Store and recall requests can come from software pulses, from a shared open-drain busy line that any device may pull low, and from two supply flags: one for the supply falling below the switch threshold and one for it falling below the reset level.

A store caused by the busy line or by power loss runs only when the array was written since the last store or recall. Software stores always run. When the line falls, reads continue for a grace window and new writes are refused. After a line-initiated request the block stays locked until the line is released, and then waits a recovery time. All durations are parameters counted in clock cycles. The array model receives one-cycle start pulses.

States: PWR_WAIT (reset, or supply low after a store), RECALL, IDLE, GRACE, STORE, PF_PULSE (power fail with nothing to save), LOCK (wait for the line to rise), RECOVER. Transitions:
- reset→PWR_WAIT; PWR_WAIT→RECALL when the supply is good and a recall is pending; PWR_WAIT→IDLE when the supply is good and none is pending.
- IDLE→STORE on power fail with dirty data, or on a software store. IDLE→PF_PULSE on power fail with clean data. IDLE→RECALL on a pending recall or a software recall. IDLE→GRACE when the line is low.
- GRACE→STORE at the end of the window if dirty, otherwise GRACE→LOCK.
- STORE→IDLE, LOCK or PWR_WAIT at the end, chosen by the store's source (software, line or power).
- PF_PULSE→PWR_WAIT; RECALL→IDLE.
- LOCK→RECOVER when the line is high; RECOVER→LOCK if the line falls again; RECOVER→IDLE at the end.
- A power fail seen in GRACE, LOCK or RECOVER takes the same path it takes from IDLE.

Top module: `nvs_seq_ctrl`

## Requirements
- R1: While reset is held, `sram_access_en`, `busy_pull`, `nv_store_go` and `nv_recall_go` are 0. With the supply good, `nv_recall_go` pulses on the first clock after reset, and `sram_access_en` stays 0 for exactly RECALL_CYC cycles counted from that pulse.
- R2: In IDLE with the line high and `vlow_flag`=0, `sram_access_en`=1 and `sram_wr_block`=0. A write strobe in that cycle marks the array dirty.
- R3: In the cycle the busy line is first seen low in IDLE, and for GRACE_CYC cycles after it, `sram_access_en`=1 and `sram_wr_block`=1. A write strobe in the same cycle as the line falls is refused.
- R4: At the end of the grace window a store starts only if the array is dirty. `nv_store_go` is high for exactly one cycle.
- R5: During any store, `busy_pull`=1 and `sram_access_en`=0 for exactly STORE_CYC cycles. After that the pull is released.
- R6: After a line-initiated request, whether or not it stored, `sram_access_en` stays 0 while the line is low. It returns to 1 exactly RECOVER_CYC+1 cycles after the cycle in which the line is first seen high.
- R7: A software store runs even when the array is clean. Access returns in the cycle right after the store ends, with no lock.
- R8: A software recall pulses `nv_recall_go` for one cycle and holds `sram_access_en` at 0 for RECALL_CYC cycles without pulling the busy line.
- R9: The dirty mark is cleared when a store or a recall completes, so a following line request does not store.
- R10: While `vlow_flag`=1, writes are blocked. Power fail with dirty data starts a store. With clean data it pulls the line for PF_PULSE_CYC cycles and starts no store.
- R11: `vreset_flag` latches a recall, which starts in the cycle after `vlow_flag` clears. A power dip without `vreset_flag` ends in IDLE with no recall.
- R12: When software store and recall requests arrive in the same cycle, the store runs and the recall request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_sw_req | input | 1 | Software store request pulse |
| recall_sw_req | input | 1 | Software recall request pulse |
| busy_line | input | 1 | Level read back from the shared open-drain busy line |
| vlow_flag | input | 1 | Supply below switch threshold |
| vreset_flag | input | 1 | Supply below reset level |
| sram_wr_req | input | 1 | SRAM write strobe |
| sram_access_en | output | 1 | SRAM read/write access allowed |
| sram_wr_block | output | 1 | New SRAM writes refused |
| busy_pull | output | 1 | Open-drain pull-down enable for the busy line |
| nv_store_go | output | 1 | One-cycle store start to the array model |
| nv_recall_go | output | 1 | One-cycle recall start to the array model |

## Verification
A write strobe and a falling busy line can land in the same cycle. The write must lose, because the line level blocks writes combinationally. The bench drives both in one cycle after a store has left the array clean. It then judges the outcome only at the ports: no `nv_store_go` may appear when the grace window ends. A second collision, software store and recall together, is judged by which start pulse appears. The rest is randomized write counts before line requests, each checked against a bench model of the dirty mark.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_RECALL,
        ST_IDLE,
        ST_GRACE,
        ST_STORE,
        ST_PF_PULSE,
        ST_LOCK,
        ST_RECOVER
    } nvs_state_e;

    typedef enum logic [1:0] {
        SRC_SW,
        SRC_HW,
        SRC_PWR
    } nvs_src_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt_q
);

    localparam logic [CW-1:0] CNT_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/nvs_nv_flags.sv
module nvs_nv_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic nv_done,
    input  logic vreset_flag,
    input  logic recall_taken,
    output logic dirty_q,
    output logic recall_pend_q
);

    // dirty: set by an accepted write, cleared when a nonvolatile cycle ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (nv_done) begin
            dirty_q <= 1'b0;
        end else if (wr_accept) begin
            dirty_q <= 1'b1;
        end
    end

    // power-on counts as a fall below the reset level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recall_pend_q <= 1'b1;
        end else if (vreset_flag) begin
            recall_pend_q <= 1'b1;
        end else if (recall_taken) begin
            recall_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int CW           = 8,
    parameter int STORE_CYC    = 16,
    parameter int RECALL_CYC   = 8,
    parameter int GRACE_CYC    = 4,
    parameter int PF_PULSE_CYC = 4,
    parameter int RECOVER_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_sw_req,
    input  logic          recall_sw_req,
    input  logic          busy_line,
    input  logic          vlow_flag,
    input  logic          dirty,
    input  logic          recall_pend,
    input  logic [CW-1:0] cnt,
    output nvs_state_e    state_q,
    output nvs_state_e    state_d,
    output logic          sram_access_en,
    output logic          sram_wr_block,
    output logic          busy_pull,
    output logic          nv_store_go,
    output logic          nv_recall_go,
    output logic          nv_done
);

    localparam logic [CW-1:0] STORE_LAST   = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RECALL_LAST  = CW'(RECALL_CYC - 1);
    localparam logic [CW-1:0] GRACE_LAST   = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] PF_LAST      = CW'(PF_PULSE_CYC - 1);
    localparam logic [CW-1:0] RECOVER_LAST = CW'(RECOVER_CYC - 1);

    nvs_src_e   src_q;
    nvs_src_e   src_d;
    nvs_state_e pf_target;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
            src_q   <= SRC_SW;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // power fail: save only dirty data, otherwise just signal on the line
    always_comb begin
        pf_target = dirty ? ST_STORE : ST_PF_PULSE;
    end

    // next state
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_PWR_WAIT: begin
                if (!vlow_flag) begin
                    state_d = recall_pend ? ST_RECALL : ST_IDLE;
                end
            end
            ST_RECALL: begin
                if (cnt == RECALL_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (vlow_flag) begin
                    state_d = pf_target;
                    src_d   = SRC_PWR;
                end else if (recall_pend) begin
                    state_d = ST_RECALL;
                end else if (store_sw_req) begin
                    state_d = ST_STORE;
                    src_d   = SRC_SW;
                end else if (recall_sw_req) begin
                    state_d = ST_RECALL;
                end else if (!busy_line) begin
                    state_d = ST_GRACE;
                end
            end
            ST_GRACE: begin
                if (vlow_flag) begin
                    state_d = pf_target;
                    src_d   = SRC_PWR;
                end else if (cnt == GRACE_LAST) begin
                    state_d = dirty ? ST_STORE : ST_LOCK;
                    src_d   = SRC_HW;
                end
            end
            ST_STORE: begin
                if (cnt == STORE_LAST) begin
                    unique case (src_q)
                        SRC_SW:  state_d = ST_IDLE;
                        SRC_HW:  state_d = ST_LOCK;
                        default: state_d = ST_PWR_WAIT;
                    endcase
                end
            end
            ST_PF_PULSE: begin
                if (cnt == PF_LAST) begin
                    state_d = ST_PWR_WAIT;
                end
            end
            ST_LOCK: begin
                if (vlow_flag) begin
                    state_d = pf_target;
                    src_d   = SRC_PWR;
                end else if (busy_line) begin
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (vlow_flag) begin
                    state_d = pf_target;
                    src_d   = SRC_PWR;
                end else if (!busy_line) begin
                    state_d = ST_LOCK;
                end else if (cnt == RECOVER_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_PWR_WAIT;
            end
        endcase
    end

    // outputs
    always_comb begin
        sram_access_en = (state_q == ST_IDLE) || (state_q == ST_GRACE);
        sram_wr_block  = (state_q != ST_IDLE) || vlow_flag || !busy_line;
        busy_pull      = (state_q == ST_STORE) || (state_q == ST_PF_PULSE);
        nv_store_go    = (state_q == ST_STORE) && (cnt == '0);
        nv_recall_go   = (state_q == ST_RECALL) && (cnt == '0);
        nv_done        = ((state_q == ST_STORE) && (cnt == STORE_LAST)) ||
                         ((state_q == ST_RECALL) && (cnt == RECALL_LAST));
    end

endmodule

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYC    = 1250000,
    parameter int RECALL_CYC   = 2500,
    parameter int GRACE_CYC    = 125,
    parameter int PF_PULSE_CYC = 125,
    parameter int RECOVER_CYC  = 88
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_sw_req,
    input  logic recall_sw_req,
    input  logic busy_line,
    input  logic vlow_flag,
    input  logic vreset_flag,
    input  logic sram_wr_req,
    output logic sram_access_en,
    output logic sram_wr_block,
    output logic busy_pull,
    output logic nv_store_go,
    output logic nv_recall_go
);

    localparam int LEN_MAX = max2(max2(max2(STORE_CYC, RECALL_CYC),
                                       max2(GRACE_CYC, PF_PULSE_CYC)),
                                  RECOVER_CYC);
    localparam int CW = $clog2(LEN_MAX + 1);

    nvs_state_e    state_q;
    nvs_state_e    state_d;
    logic [CW-1:0] cnt;
    logic          dirty;
    logic          recall_pend;
    logic          nv_done;
    logic          wr_accept;

    assign wr_accept = sram_wr_req && !sram_wr_block;

    nvs_cycle_timer #(.CW(CW)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .cnt_q   (cnt)
    );

    nvs_nv_flags i_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_accept     (wr_accept),
        .nv_done       (nv_done),
        .vreset_flag   (vreset_flag),
        .recall_taken  (nv_recall_go),
        .dirty_q       (dirty),
        .recall_pend_q (recall_pend)
    );

    nvs_fsm #(
        .CW           (CW),
        .STORE_CYC    (STORE_CYC),
        .RECALL_CYC   (RECALL_CYC),
        .GRACE_CYC    (GRACE_CYC),
        .PF_PULSE_CYC (PF_PULSE_CYC),
        .RECOVER_CYC  (RECOVER_CYC)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .store_sw_req   (store_sw_req),
        .recall_sw_req  (recall_sw_req),
        .busy_line      (busy_line),
        .vlow_flag      (vlow_flag),
        .dirty          (dirty),
        .recall_pend    (recall_pend),
        .cnt            (cnt),
        .state_q        (state_q),
        .state_d        (state_d),
        .sram_access_en (sram_access_en),
        .sram_wr_block  (sram_wr_block),
        .busy_pull      (busy_pull),
        .nv_store_go    (nv_store_go),
        .nv_recall_go   (nv_recall_go),
        .nv_done        (nv_done)
    );

endmodule

// File: rtl/nvs_seq_ctrl_chk.sv
module nvs_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_line,
    input logic vlow_flag,
    input logic sram_access_en,
    input logic sram_wr_block,
    input logic busy_pull,
    input logic nv_store_go,
    input logic nv_recall_go
);

    p_store_pulls_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nv_store_go |-> busy_pull);

    p_no_access_while_pull_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> !sram_access_en);

    p_store_go_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nv_store_go |=> !nv_store_go);

    p_recall_go_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_recall_go |=> !nv_recall_go);

    p_recall_no_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_recall_go |-> (!busy_pull && !sram_access_en));

    p_vlow_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_flag |-> sram_wr_block);

    p_line_low_blocks_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_line |-> sram_wr_block);

    p_single_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_store_go && nv_recall_go));

endmodule

bind nvs_seq_ctrl nvs_seq_ctrl_chk i_chk (.*);

// File: tb/test_nvs_seq_ctrl.sv
module test_nvs_seq_ctrl;

    localparam int STORE_CYC    = 20;
    localparam int RECALL_CYC   = 12;
    localparam int GRACE_CYC    = 6;
    localparam int PF_PULSE_CYC = 8;
    localparam int RECOVER_CYC  = 5;
    localparam int LOOP_MAX     = 10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic store_sw_req = 1'b0;
    logic recall_sw_req = 1'b0;
    logic ext_low = 1'b0;
    logic vlow_flag = 1'b0;
    logic vreset_flag = 1'b0;
    logic sram_wr_req = 1'b0;
    logic busy_line;
    logic sram_access_en;
    logic sram_wr_block;
    logic busy_pull;
    logic nv_store_go;
    logic nv_recall_go;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // wired-AND open-drain line shared with another device
    assign busy_line = !(busy_pull || ext_low);

    always #4 clk = !clk;

    nvs_seq_ctrl #(
        .STORE_CYC    (STORE_CYC),
        .RECALL_CYC   (RECALL_CYC),
        .GRACE_CYC    (GRACE_CYC),
        .PF_PULSE_CYC (PF_PULSE_CYC),
        .RECOVER_CYC  (RECOVER_CYC)
    ) i_nvs_seq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .store_sw_req   (store_sw_req),
        .recall_sw_req  (recall_sw_req),
        .busy_line      (busy_line),
        .vlow_flag      (vlow_flag),
        .vreset_flag    (vreset_flag),
        .sram_wr_req    (sram_wr_req),
        .sram_access_en (sram_access_en),
        .sram_wr_block  (sram_wr_block),
        .busy_pull      (busy_pull),
        .nv_store_go    (nv_store_go),
        .nv_recall_go   (nv_recall_go)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive point: just after an edge
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // sample point: away from the edge
    task automatic stp();
        @(posedge clk);
        #2;
    endtask

    function automatic bit exp_store(input int writes_since_nv);
        return writes_since_nv > 0;
    endfunction

    task automatic count_pull(output int n, output int starts);
        n = 0;
        starts = 0;
        while (busy_pull && n < LOOP_MAX) begin
            n++;
            if (nv_store_go) starts++;
            stp();
        end
    endtask

    task automatic count_noaccess(output int n);
        n = 0;
        while (!sram_access_en && n < LOOP_MAX) begin
            n++;
            stp();
        end
    endtask

    task automatic do_write();
        cyc();
        sram_wr_req = 1'b1;
        #1;
        chk(!sram_wr_block, "R2 write accepted in idle", sram_wr_block, 0);
        cyc();
        sram_wr_req = 1'b0;
        #1;
    endtask

    // line pulled low by the other device, held, then released
    task automatic line_request(input bit expect_store, input int hold);
        int n;
        int starts;
        int bad;
        cyc();
        ext_low = 1'b1;
        #1;
        chk(sram_access_en && sram_wr_block, "R3 grace entry", {sram_access_en, sram_wr_block}, 3);
        bad = 0;
        for (int g = 0; g < GRACE_CYC; g++) begin
            stp();
            if (!(sram_access_en && sram_wr_block)) bad++;
        end
        chk(bad == 0, "R3 grace window", bad, 0);
        stp();
        chk(nv_store_go == expect_store, "R4 store only if dirty", nv_store_go, expect_store);
        if (expect_store) begin
            count_pull(n, starts);
            chk(n == STORE_CYC, "R5 store length", n, STORE_CYC);
            chk(starts == 1, "R4 store pulse width", starts, 1);
        end
        bad = 0;
        for (int h = 0; h < hold; h++) begin
            if (sram_access_en) bad++;
            stp();
        end
        chk(bad == 0, "R6 locked while line low", bad, 0);
        cyc();
        ext_low = 1'b0;
        #1;
        count_noaccess(n);
        chk(n == RECOVER_CYC + 1, "R6 recovery", n, RECOVER_CYC + 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int starts;
        int bad;
        int nw;
        int hold;
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);

        // R1 reset state
        repeat (3) stp();
        chk(!sram_access_en && !busy_pull && !nv_store_go && !nv_recall_go,
            "R1 reset outputs", {sram_access_en, busy_pull, nv_store_go, nv_recall_go}, 0);
        cyc();
        rst_n = 1'b1;
        #1;
        n = 0;
        while (!nv_recall_go && n < 10) begin
            n++;
            stp();
        end
        chk(nv_recall_go, "R1 power-on recall pulse", nv_recall_go, 1);
        count_noaccess(n);
        chk(n == RECALL_CYC, "R1 power-on recall length", n, RECALL_CYC);

        // R2 idle access
        chk(sram_access_en && !sram_wr_block, "R2 idle access", {sram_access_en, sram_wr_block}, 2);

        // R3 R4 R5 R6: dirty, line request stores then locks
        do_write();
        line_request(1'b1, 3);

        // R9: store cleared dirty, next line request does not store
        line_request(1'b0, 2);

        // R3: write and line fall in the same cycle, write refused
        cyc();
        sram_wr_req = 1'b1;
        ext_low = 1'b1;
        #1;
        chk(sram_wr_block, "R3 same-cycle write refused", sram_wr_block, 1);
        cyc();
        sram_wr_req = 1'b0;
        #1;
        bad = 0;
        for (int i = 0; i < GRACE_CYC + 3; i++) begin
            if (nv_store_go) bad++;
            stp();
        end
        chk(bad == 0, "R3 no store after refused write", bad, 0);
        cyc();
        ext_low = 1'b0;
        #1;
        count_noaccess(n);
        chk(n == RECOVER_CYC + 1, "R6 recovery after clean request", n, RECOVER_CYC + 1);

        // R7 software store on clean data
        cyc();
        store_sw_req = 1'b1;
        #1;
        cyc();
        store_sw_req = 1'b0;
        #1;
        chk(nv_store_go, "R7 software store starts", nv_store_go, 1);
        count_pull(n, starts);
        chk(n == STORE_CYC, "R7 software store length", n, STORE_CYC);
        chk(sram_access_en, "R7 no lock after software store", sram_access_en, 1);

        // R8 software recall, R9 recall clears dirty
        do_write();
        cyc();
        recall_sw_req = 1'b1;
        #1;
        cyc();
        recall_sw_req = 1'b0;
        #1;
        chk(nv_recall_go && !busy_pull, "R8 recall pulse without pull", {nv_recall_go, busy_pull}, 2);
        count_noaccess(n);
        chk(n == RECALL_CYC, "R8 recall length", n, RECALL_CYC);
        line_request(1'b0, 1);

        // R10 R11 power dip, clean, no reset level
        cyc();
        vlow_flag = 1'b1;
        #1;
        chk(sram_wr_block, "R10 writes blocked on low supply", sram_wr_block, 1);
        stp();
        chk(busy_pull && !nv_store_go, "R10 clean power fail pulse", {busy_pull, nv_store_go}, 2);
        count_pull(n, starts);
        chk(n == PF_PULSE_CYC && starts == 0, "R10 pulse length no store", n, PF_PULSE_CYC);
        stp();
        chk(!sram_access_en, "R10 access off while supply low", sram_access_en, 0);
        cyc();
        vlow_flag = 1'b0;
        #1;
        stp();
        chk(sram_access_en && !nv_recall_go, "R11 no recall without reset level",
            {sram_access_en, nv_recall_go}, 2);

        // R10 R11 power fail with dirty data, reset level reached
        do_write();
        cyc();
        vlow_flag = 1'b1;
        #1;
        stp();
        chk(nv_store_go, "R10 dirty power fail stores", nv_store_go, 1);
        count_pull(n, starts);
        chk(n == STORE_CYC, "R10 power store length", n, STORE_CYC);
        cyc();
        vreset_flag = 1'b1;
        #1;
        cyc();
        vreset_flag = 1'b0;
        #1;
        stp();
        chk(!nv_recall_go, "R11 no recall while supply low", nv_recall_go, 0);
        cyc();
        vlow_flag = 1'b0;
        #1;
        stp();
        chk(nv_recall_go, "R11 recall on supply return", nv_recall_go, 1);
        count_noaccess(n);
        chk(n == RECALL_CYC, "R11 recall length", n, RECALL_CYC);

        // R12 simultaneous software requests
        cyc();
        store_sw_req = 1'b1;
        recall_sw_req = 1'b1;
        #1;
        cyc();
        store_sw_req = 1'b0;
        recall_sw_req = 1'b0;
        #1;
        chk(nv_store_go && !nv_recall_go, "R12 store wins", {nv_store_go, nv_recall_go}, 2);
        count_pull(n, starts);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            if (nv_recall_go || !sram_access_en) bad++;
            stp();
        end
        chk(bad == 0, "R12 recall dropped", bad, 0);

        // random: write counts before line requests, R4 against bench model
        for (int it = 0; it < 10; it++) begin
            nw = $urandom_range(0, 2);
            for (int w = 0; w < nw; w++) begin
                do_write();
                repeat ($urandom_range(0, 2)) stp();
            end
            hold = $urandom_range(1, 4);
            line_request(exp_store(nw), hold);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule